// File: doc/BRIEF.md
# SPI Master/Slave Controller with Mode-Fault Demotion

This block is an 8-bit serial peripheral port that runs either as the bus master or as a slave. Software reaches it through three byte-wide registers: control, status and data. As master it makes the serial clock from the system clock with a selectable divider and runs in mode 0. It drives the most significant bit first on its data output and samples the returned bit on each rising clock edge. The same shift register serves both directions, so the master and the far-end slave exchange bytes around a ring.

As slave, the select, clock and data inputs pass through two-flop synchronizers. The block shifts only while select is low, and taking select high throws away any partial byte. The transmit side has a single buffer: a data write during a shift is refused and flagged as a collision. The receive side has two buffers: each finished byte is copied into a read register, and the next finished byte overwrites it.

The block also drives output enables for its serial clock, its master data output and its slave data output. When it acts as master with select configured as an input and select is pulled low, it treats this as a competing master. It clears its own master bit, releases its outputs, raises the completion flag and stays a slave until software sets the master bit again.

Top module: `spi_mf_ctrl`

## Requirements
- R1: After reset, all three registers read 0x00, every output enable is 0 and `irq` is 0.
- R2: In master mode a data write (address 2) with no transfer running starts a transfer. SCK idles low. `mosi_o` presents the byte most significant bit first. `miso_i` is sampled on each SCK rising edge and shifted in on the falling edge. After 8 bits the received byte reads back at address 2 and status bit 7 is set.
- R3: Control bits [4:3] set the SCK half-period: 00 gives 2, 01 gives 8, 10 gives 32 and 11 gives 64 system clocks (SCK period 4, 16, 64, 128).
- R4: A data write while a transfer is in progress leaves the shifted byte unchanged and sets status bit 6 (write collision).
- R5: Status bits 7 and 6 clear when the status register (address 1) is read while bit 7 is set and the data register is then accessed.
- R6: The read buffer keeps the last finished byte while the next one shifts in. A second finished byte that nobody read replaces the first.
- R7: In slave mode (control bit 0 = 1, bit 1 = 0) with SS low, bytes shift in from `mosi_i` on SCK edges. `miso_o` gives out the loaded byte most significant bit first. `miso_oe` equals control bit 6 while SS is low.
- R8: In slave mode with SS high, SCK activity is ignored, no flag is set, the read buffer is unchanged, `miso_oe` is 0, and a partial byte already shifted is discarded.
- R9: In master mode with control bit 5 = 1 (SS as output), the SS input level has no effect.
- R10: In master mode with control bit 5 = 0, SS low clears control bit 1 and aborts the transfer. It also sets status bit 7 and drops `sck_oe` and `mosi_oe`.
- R11: After a mode fault the block stays a slave when SS returns high, until software writes control bit 1 = 1.
- R12: `irq` is high exactly when status bit 7 and control bit 2 are both set.
- R13: In master mode `sck_oe` and `mosi_oe` are 1 and `miso_oe` is 0. With control bit 0 = 0, all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Completion interrupt |
| sck_i | input | 1 | Serial clock from the pin |
| sck_o | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master data from the pin (slave receive) |
| mosi_o | output | 1 | Master data driven as master |
| mosi_oe | output | 1 | Master data output enable |
| miso_i | input | 1 | Slave data from the pin (master receive) |
| miso_o | output | 1 | Slave data driven as slave |
| miso_oe | output | 1 | Slave data output enable |
| ss_i | input | 1 | Slave select from the pin |

## Verification
The assertions assume that each register access is a one-cycle strobe. They also assume that the slave-side SCK, MOSI and SS inputs are held steady for several system clocks around each change, so the synchronizers never pass a half-formed edge. The bench acting as master keeps every SCK phase eight clocks long and changes MOSI only while SCK is low. It lowers or raises SS only while SCK is idle, and it waits out the synchronizer delay before it reads status.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;

  localparam int unsigned CTL_W = 7;

  typedef enum logic [1:0] {
    ADDR_CTL = 2'd0,
    ADDR_STS = 2'd1,
    ADDR_DAT = 2'd2
  } spi_addr_e;

  typedef struct packed {
    logic       miso_en;  // bit 6
    logic       ss_out;   // bit 5
    logic [1:0] div;      // bits 4:3
    logic       ie;       // bit 2
    logic       mstr;     // bit 1
    logic       en;       // bit 0
  } spi_ctl_t;

  function automatic int unsigned half_period(input logic [1:0] sel);
    case (sel)
      2'd0:    half_period = 2;
      2'd1:    half_period = 8;
      2'd2:    half_period = 32;
      default: half_period = 64;
    endcase
  endfunction

endpackage

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
  parameter int unsigned N       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  localparam int unsigned CHAIN_W = N * STAGES;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-N-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[CHAIN_W-1 -: N];
endmodule

// File: rtl/spi_mf_clkdiv.sv
module spi_mf_clkdiv #(
  parameter int unsigned CW = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = CW'(spi_mf_pkg::half_period(sel) - 1);
    tick  = run && (cnt_q == lim);
    cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_mf_ctrl.sv
module spi_mf_ctrl
  import spi_mf_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_W       = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          ss_i
);
  localparam int unsigned BC_W = $clog2(DW);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DW - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign srst_n = rst_pipe_q[1];

  // synchronized slave-side pins
  logic ss_s, sck_s, mosi_s;
  spi_mf_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(srst_n), .d({ss_i, sck_i, mosi_i}), .q({ss_s, sck_s, mosi_s})
  );

  // state
  spi_ctl_t        ctl_q, ctl_d;
  logic            flag_q, flag_d, wcol_q, wcol_d, arm_q, arm_d;
  logic [DW-1:0]   sr_q, sr_d, rbuf_q, rbuf_d;
  logic            samp_q, samp_d, phase_q, phase_d, run_q, run_d, sck_q, sck_d, sck_s_d;
  logic [BC_W-1:0] bit_q, bit_d;

  logic tick;
  spi_mf_clkdiv #(.CW(DIV_W)) u_div (
    .clk(clk), .rst_n(srst_n), .run(run_q), .sel(ctl_q.div), .tick(tick)
  );

  // decode
  logic wr_ctl, rd_sts, acc_dat, wr_dat, is_m, is_s, busy, fault, sck_rise, sck_fall;
  logic flag_set, wcol_set;
  logic unused_wbits;
  assign unused_wbits = ^reg_wdata[DW-1:CTL_W];

  always_comb begin
    wr_ctl   = reg_sel && reg_wr && (reg_addr == ADDR_CTL);
    rd_sts   = reg_sel && !reg_wr && (reg_addr == ADDR_STS);
    acc_dat  = reg_sel && (reg_addr == ADDR_DAT);
    wr_dat   = acc_dat && reg_wr;
    is_m     = ctl_q.en && ctl_q.mstr;
    is_s     = ctl_q.en && !ctl_q.mstr;
    busy     = run_q || (is_s && (phase_q || (bit_q != '0)));
    fault    = is_m && !ctl_q.ss_out && !ss_s;
    sck_rise = sck_s && !sck_s_d;
    sck_fall = !sck_s && sck_s_d;
  end

  // next state
  always_comb begin
    ctl_d = ctl_q;  flag_d = flag_q; wcol_d = wcol_q; arm_d = arm_q;
    sr_d = sr_q;    rbuf_d = rbuf_q; samp_d = samp_q; phase_d = phase_q;
    run_d = run_q;  sck_d = sck_q;   bit_d = bit_q;
    flag_set = 1'b0; wcol_set = 1'b0;

    if (wr_ctl) ctl_d = spi_ctl_t'(reg_wdata[CTL_W-1:0]);

    if (!ctl_q.en) begin
      run_d = 1'b0; sck_d = 1'b0; bit_d = '0; phase_d = 1'b0;
    end else if (fault) begin
      ctl_d.mstr = 1'b0;
      run_d = 1'b0; sck_d = 1'b0; bit_d = '0; phase_d = 1'b0;
      flag_set = 1'b1;
    end else if (is_m) begin
      if (tick) begin
        if (!sck_q) begin
          sck_d  = 1'b1;
          samp_d = miso_i;
        end else begin
          sck_d = 1'b0;
          sr_d  = {sr_q[DW-2:0], samp_q};
          bit_d = bit_q + 1'b1;
          if (bit_q == LAST_BIT) begin
            run_d    = 1'b0;
            bit_d    = '0;
            rbuf_d   = {sr_q[DW-2:0], samp_q};
            flag_set = 1'b1;
          end
        end
      end
    end else begin
      run_d = 1'b0; sck_d = 1'b0;
      if (ss_s) begin
        bit_d = '0; phase_d = 1'b0;
      end else if (sck_rise) begin
        samp_d = mosi_s; phase_d = 1'b1;
      end else if (sck_fall && phase_q) begin
        phase_d = 1'b0;
        sr_d    = {sr_q[DW-2:0], samp_q};
        bit_d   = bit_q + 1'b1;
        if (bit_q == LAST_BIT) begin
          bit_d    = '0;
          rbuf_d   = {sr_q[DW-2:0], samp_q};
          flag_set = 1'b1;
        end
      end
    end

    if (wr_dat && ctl_q.en && !fault) begin
      if (busy) wcol_set = 1'b1;
      else begin
        sr_d = reg_wdata;
        if (is_m) run_d = 1'b1;
      end
    end

    if (rd_sts && flag_q) arm_d = 1'b1;
    if (acc_dat && arm_q) begin
      flag_d = 1'b0; wcol_d = 1'b0; arm_d = 1'b0;
    end
    if (flag_set) flag_d = 1'b1;
    if (wcol_set) wcol_d = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctl_q <= '0;  flag_q <= 1'b0; wcol_q <= 1'b0; arm_q <= 1'b0;
      sr_q <= '0;   rbuf_q <= '0;   samp_q <= 1'b0; phase_q <= 1'b0;
      run_q <= 1'b0; sck_q <= 1'b0; bit_q <= '0;    sck_s_d <= 1'b0;
    end else begin
      ctl_q <= ctl_d;  flag_q <= flag_d; wcol_q <= wcol_d; arm_q <= arm_d;
      sr_q <= sr_d;    rbuf_q <= rbuf_d; samp_q <= samp_d; phase_q <= phase_d;
      run_q <= run_d;  sck_q <= sck_d;   bit_q <= bit_d;   sck_s_d <= sck_s;
    end
  end

  // outputs
  always_comb begin
    case (reg_addr)
      ADDR_CTL: reg_rdata = DW'(ctl_q);
      ADDR_STS: reg_rdata = {flag_q, wcol_q, {(DW-2){1'b0}}};
      ADDR_DAT: reg_rdata = rbuf_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq     = flag_q && ctl_q.ie;
  assign sck_o   = sck_q;
  assign mosi_o  = sr_q[DW-1];
  assign miso_o  = sr_q[DW-1];
  assign sck_oe  = is_m;
  assign mosi_oe = is_m;
  assign miso_oe = is_s && ctl_q.miso_en && !ss_s;

  // R10
  modf_demote_chk: assert property (@(posedge clk) disable iff (!srst_n)
    fault |=> (!ctl_q.mstr && flag_q && !run_q));

  // R4
  wcol_flag_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_dat && ctl_q.en && busy && !fault) |=> wcol_q);

  // R8
  ss_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (is_s && ss_s && !wr_ctl) |=> ((bit_q == '0) && !phase_q));

  // R12
  irq_src_chk: assert property (@(posedge clk) disable iff (!srst_n)
    irq |-> flag_q);

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !run_q |-> !sck_o);
endmodule

// File: tb/spi_mf_ctrl_bench.sv
`timescale 1ns/1ps
module spi_mf_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       reg_sel = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, miso_i;
  logic sck_i = 1'b0, mosi_i = 1'b0, ss_i = 1'b1;

  spi_mf_ctrl u_spi_mf_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_i(ss_i)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural far-end slave used while the block is master
  logic [7:0] bs_byte = 8'h00;
  int bs_base = 0, bs_falls = 0;
  logic [7:0] bs_cap = 8'h00;
  int bs_idx;
  assign bs_idx = bs_falls - bs_base;
  assign miso_i = (bs_idx >= 0 && bs_idx < 8) ? bs_byte[3'(7 - bs_idx)] : 1'b0;
  always @(negedge sck_o) bs_falls <= bs_falls + 1;
  always @(posedge sck_o) bs_cap <= {bs_cap[6:0], mosi_o};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_sel = 1'b0;
  endtask

  task automatic clear_flag();
    logic [7:0] t;
    rd(2'd1, t); rd(2'd2, t);
  endtask

  task automatic arm_slave(input logic [7:0] b);
    bs_byte = b; bs_base = bs_falls;
  endtask

  // bench acting as master on the slave-side pins, sends bits lo..hi of tx
  task automatic m_xfer(input logic [7:0] tx, input int lo, input int hi, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = lo; i <= hi; i++) begin
      mosi_i = tx[3'(7 - i)];
      repeat (8) @(negedge clk);
      sck_i = 1'b1; rx = {rx[6:0], miso_o};
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic sck_period(output int p);
    int t0;
    @(posedge sck_o); t0 = cyc;
    @(posedge sck_o); p = cyc - t0;
  endtask

  initial begin
    logic [7:0] v, rx;
    int p;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctl", v, 8'h00);
    rd(2'd1, v); chk("R1 sts", v, 8'h00);
    rd(2'd2, v); chk("R1 dat", v, 8'h00);
    chk("R1 oe", {sck_oe, mosi_oe, miso_oe, irq}, 4'b0000);

    // R13 master enables: en|mstr|ie|ss_out, div 00
    wr(2'd0, 8'h27);
    chk("R13 master oe", {sck_oe, mosi_oe, miso_oe}, 3'b110);

    // R2 master exchange, R4 collision during it
    arm_slave(8'h3C);
    wr(2'd2, 8'hA5);
    repeat (4) @(negedge clk);
    wr(2'd2, 8'hFF);
    repeat (60) @(negedge clk);
    chk("R2/R4 byte on mosi", bs_cap, 8'hA5);
    chk("R12 irq raised", irq, 1'b1);
    rd(2'd1, v); chk("R4 status flag+wcol", v, 8'hC0);
    rd(2'd2, v); chk("R2 received byte", v, 8'h3C);
    rd(2'd1, v); chk("R5 status cleared", v, 8'h00);
    chk("R12 irq cleared", irq, 1'b0);

    // R3 divider
    wr(2'd0, 8'h2F);
    arm_slave(8'h00);
    wr(2'd2, 8'h00);
    sck_period(p); chk("R3 div01 period", p, 16);
    repeat (200) @(negedge clk); clear_flag();
    wr(2'd0, 8'h3F);
    arm_slave(8'h00);
    wr(2'd2, 8'h00);
    sck_period(p); chk("R3 div11 period", p, 128);
    repeat (1100) @(negedge clk); clear_flag();

    // R9 ss as output: low SS has no effect
    wr(2'd0, 8'h27);
    ss_i = 1'b0;
    repeat (10) @(negedge clk);
    rd(2'd0, v); chk("R9 ctl kept", v, 8'h27);
    arm_slave(8'h81);
    wr(2'd2, 8'h42);
    repeat (60) @(negedge clk);
    chk("R9 mosi byte", bs_cap, 8'h42);
    rd(2'd1, v); rd(2'd2, v); chk("R9 rx byte", v, 8'h81);
    ss_i = 1'b1;
    repeat (6) @(negedge clk);

    // R10 mode fault mid-transfer
    wr(2'd0, 8'h07);
    arm_slave(8'h00);
    wr(2'd2, 8'h99);
    repeat (10) @(negedge clk);
    ss_i = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd0, v); chk("R10 master bit cleared", v, 8'h05);
    chk("R10 oe released", {sck_oe, mosi_oe, sck_o}, 3'b000);
    chk("R10/R12 irq", irq, 1'b1);
    rd(2'd1, v); chk("R10 flag", v[7], 1'b1);
    rd(2'd2, v);

    // R11 stays slave
    ss_i = 1'b1;
    repeat (10) @(negedge clk);
    rd(2'd0, v); chk("R11 still slave", v, 8'h05);
    wr(2'd0, 8'h07);
    chk("R11 master restored", sck_oe, 1'b1);

    // R7 slave: en|ie|miso_en
    wr(2'd0, 8'h45);
    repeat (4) @(negedge clk);
    chk("R8 miso_oe with ss high", miso_oe, 1'b0);
    wr(2'd2, 8'h96);
    ss_i = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 miso_oe with ss low", miso_oe, 1'b1);
    m_xfer(8'h3A, 0, 7, rx);
    chk("R7 miso byte", rx, 8'h96);
    rd(2'd1, v); chk("R7 flag", v, 8'h80);
    rd(2'd2, v); chk("R7 rx byte", v, 8'h3A);

    // R6 double buffer
    m_xfer(8'h11, 0, 7, rx);
    m_xfer(8'h22, 0, 3, rx);
    rd(2'd2, v); chk("R6 held during shift", v, 8'h11);
    m_xfer(8'h22, 4, 7, rx);
    rd(2'd2, v); chk("R6 next byte", v, 8'h22);
    m_xfer(8'h33, 0, 7, rx);
    m_xfer(8'h44, 0, 7, rx);
    rd(2'd2, v); chk("R6 overrun keeps last", v, 8'h44);
    clear_flag();

    // R8 partial byte discarded by SS high
    m_xfer(8'hF0, 0, 3, rx);
    ss_i = 1'b1; repeat (6) @(negedge clk);
    ss_i = 1'b0; repeat (6) @(negedge clk);
    m_xfer(8'h5A, 0, 7, rx);
    rd(2'd1, v); rd(2'd2, v); chk("R8 realigned byte", v, 8'h5A);

    // R8 ignored while SS high
    ss_i = 1'b1; repeat (6) @(negedge clk);
    m_xfer(8'hC3, 0, 7, rx);
    rd(2'd1, v); chk("R8 no flag", v, 8'h00);
    rd(2'd2, v); chk("R8 buffer unchanged", v, 8'h5A);
    chk("R8 miso_oe off", miso_oe, 1'b0);

    // R13 disabled
    wr(2'd0, 8'h00);
    repeat (2) @(negedge clk);
    chk("R13 all oe off", {sck_oe, mosi_oe, miso_oe}, 3'b000);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule